// File: doc/BRIEF.md
# Two-Read Byte-Wide Result Port

This block sits between a 10-bit sampling converter and a host bus that is only eight bits wide. When the converter lowers its busy flag at the end of a conversion, the block stores the new result in a holding register. The host then fetches the result with two read accesses. Each access is qualified by an active-low chip-select and an active-low read strobe. The first access returns the upper eight bits. The second returns the two lowest bits, placed at the top of the byte with zeros below them. Reads after that alternate between the same two bytes.

A read pointer selects which byte is presented. Every time busy rises, the pointer goes back to the upper byte. A host that only wants eight-bit precision can therefore read once per conversion and never touch the low byte. The bus drivers are represented by an output-enable together with a data word. While the enable is low, and while a conversion is running, the data word is held at zero.

The strobes pass through a two-stage synchroniser before the block uses them. A read access ends when the synchronised read strobe rises while the synchronised chip-select is still low.

Top module: `bp_result_port`

## Requirements
- R1: `bus_oe` is 1 exactly when both synchronised strobes are low. Whenever `bus_oe` is 0, `bus_data` is all zeros.
- R2: The first read access after a capture, or after busy has risen, returns result bits [9:2] on `bus_data[7:0]`.
- R3: The second read access returns result bits [1:0] on `bus_data[7:6]`, with `bus_data[5:0]` equal to zero.
- R4: Further completed accesses keep alternating between the upper byte and the lower byte of the same stored result.
- R5: On the cycle after busy is first seen high, the pointer selects the upper byte, however many accesses came before.
- R6: The stored result loads `res_data` on the clock at which busy is seen low after being high, provided `res_valid` is 1 on that clock. A busy fall without `res_valid` keeps the old result.
- R7: While `busy` is 1, `bus_data` is zero, and completed read accesses do not move the pointer.
- R8: A rise of the read strobe while chip-select is high is not a completed access, so the pointer does not move.
- R9: After reset the stored result is zero, the pointer selects the upper byte, and `bus_oe` is 0.
- R10: A change on `cs_n` or `rd_n` reaches `bus_oe` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select strobe, active low, asynchronous to clk |
| rd_n | input | 1 | Read strobe, active low, asynchronous to clk |
| busy | input | 1 | High while the converter is converting |
| res_data | input | 10 | Conversion result |
| res_valid | input | 1 | Qualifies `res_data` on the busy falling clock |
| bus_data | output | 8 | Byte presented to the host |
| bus_oe | output | 1 | Enable for the host-side drivers |

## Verification
Several behaviours are checked by assertions on every cycle:
- the bus reads zero while disabled or while busy;
- the low byte carries zero padding;
- the pointer returns to the upper byte after busy rises;
- the pointer stays frozen through a busy period;
- the stored result holds across a busy fall that has no valid strobe.

Other behaviours only the bench scenarios can show: the order in which a byte pair is returned across repeated accesses, the two-edge strobe latency, that a read with chip-select high is ignored, and the eight-bit usage pattern in which the host reads one byte per conversion.

// File: rtl/bp_port_pkg.sv
package bp_port_pkg;

    localparam int RES_W_DEF  = 10;
    localparam int BUS_W_DEF  = 8;
    localparam int SYNC_DEF   = 2;

    typedef enum logic {
        SEL_HI = 1'b0,
        SEL_LO = 1'b1
    } byte_sel_e;

endpackage

// File: rtl/bp_strobe_sync.sv
module bp_strobe_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_d;
    logic [STAGES-1:0][W-1:0] stage_q;

    always_comb begin
        stage_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bp_edge_track.sv
module bp_edge_track #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_i,
    output logic prev_o,
    output logic rise_o,
    output logic fall_o
);

    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = cur_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign prev_o = prev_q;
    assign rise_o = cur_i & ~prev_q;
    assign fall_o = ~cur_i & prev_q;

endmodule

// File: rtl/bp_byte_select.sv
module bp_byte_select
    import bp_port_pkg::*;
#(
    parameter int RES_W = RES_W_DEF,
    parameter int BUS_W = BUS_W_DEF
) (
    input  logic [RES_W-1:0] res_i,
    input  byte_sel_e        sel_i,
    input  logic             drive_i,
    output logic [BUS_W-1:0] byte_o
);

    localparam int LO_W  = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - LO_W;

    logic [BUS_W-1:0] hi_byte;
    logic [BUS_W-1:0] lo_byte;

    assign hi_byte = res_i[RES_W-1:LO_W];

    generate
        if (PAD_W > 0) begin : g_padded
            assign lo_byte = {res_i[LO_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_full
            assign lo_byte = res_i[LO_W-1:0];
        end
    endgenerate

    always_comb begin
        byte_o = '0;
        if (drive_i) begin
            byte_o = (sel_i == SEL_LO) ? lo_byte : hi_byte;
        end
    end

endmodule

// File: rtl/bp_result_port.sv
module bp_result_port
    import bp_port_pkg::*;
#(
    parameter int RES_W       = RES_W_DEF,
    parameter int BUS_W       = BUS_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             busy,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_valid,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_oe
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        byte_sel_e        sel;
    } port_state_t;

    port_state_t state_d;
    port_state_t state_q;

    logic [1:0] strobe_sync;
    logic       cs_s;
    logic       rd_s;
    logic       rd_prev;
    logic       rd_rise;
    logic       rd_fall;
    logic       busy_prev;
    logic       busy_rise;
    logic       busy_fall;
    logic       access_done;

    bp_strobe_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({cs_n, rd_n}),
        .sync_o (strobe_sync)
    );

    assign cs_s = strobe_sync[1];
    assign rd_s = strobe_sync[0];

    bp_edge_track #(.RST_VAL(1'b1)) i_rd_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (rd_s),
        .prev_o (rd_prev),
        .rise_o (rd_rise),
        .fall_o (rd_fall)
    );

    bp_edge_track #(.RST_VAL(1'b0)) i_busy_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (busy),
        .prev_o (busy_prev),
        .rise_o (busy_rise),
        .fall_o (busy_fall)
    );

    // end of an access: read strobe released while the chip is still selected
    assign access_done = rd_rise & ~cs_s;

    always_comb begin
        state_d = state_q;
        if (busy_rise) begin
            state_d.sel = SEL_HI;
        end else if (!busy && access_done) begin
            state_d.sel = (state_q.sel == SEL_HI) ? SEL_LO : SEL_HI;
        end
        if (busy_fall && res_valid) begin
            state_d.res = res_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{res: '0, sel: SEL_HI};
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_oe = ~cs_s & ~rd_s;

    bp_byte_select #(
        .RES_W (RES_W),
        .BUS_W (BUS_W)
    ) i_select (
        .res_i   (state_q.res),
        .sel_i   (state_q.sel),
        .drive_i (bus_oe & ~busy),
        .byte_o  (bus_data)
    );

    logic unused_ok;
    assign unused_ok = rd_fall ^ rd_prev;

endmodule

// File: rtl/bp_result_port_chk.sv
module bp_result_port_chk #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             res_valid,
    input logic [BUS_W-1:0] bus_data,
    input logic             bus_oe,
    input logic             sel,
    input logic             busy_q,
    input logic [RES_W-1:0] res_q
);

    localparam int LO_W  = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - LO_W;
    localparam logic [BUS_W-1:0] PAD_MASK = BUS_W'((1 << PAD_W) - 1);

    // R1
    released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_data == '0);

    // R7
    busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bus_data == '0);

    // R3
    lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !busy && sel) |-> (bus_data & PAD_MASK) == '0);

    // R5
    busy_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_q) |=> !sel);

    // R7
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_q) |=> $stable(sel));

    // R6
    no_valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy && !res_valid) |=> $stable(res_q));

endmodule

bind bp_result_port bp_result_port_chk #(
    .RES_W (RES_W),
    .BUS_W (BUS_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .res_valid (res_valid),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe),
    .sel       (state_q.sel),
    .busy_q    (busy_prev),
    .res_q     (state_q.res)
);

// File: tb/test_bp_result_port.sv
module test_bp_result_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       busy = 1'b0;
    logic [9:0] res_data = '0;
    logic       res_valid = 1'b0;
    logic [7:0] bus_data;
    logic       bus_oe;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    // reference model state
    int cs_hist[$] = '{1, 1, 1};
    int rd_hist[$] = '{1, 1, 1};
    int m_busy_prev = 0;
    int m_ptr = 0;
    int m_res = 0;

    always #4 clk = ~clk;

    bp_result_port i_bp_result_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .busy      (busy),
        .res_data  (res_data),
        .res_valid (res_valid),
        .bus_data  (bus_data),
        .bus_oe    (bus_oe)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            cs_hist = '{1, 1, 1};
            rd_hist = '{1, 1, 1};
            m_busy_prev = 0;
            m_ptr = 0;
            m_res = 0;
        end else begin
            if (busy && !m_busy_prev) m_ptr = 0;
            else if (!busy && rd_hist[1] == 1 && rd_hist[2] == 0 && cs_hist[1] == 0)
                m_ptr = 1 - m_ptr;
            if (!busy && m_busy_prev && res_valid) m_res = int'(res_data);
            m_busy_prev = int'(busy);
            cs_hist.push_front(int'(cs_n)); void'(cs_hist.pop_back());
            rd_hist.push_front(int'(rd_n)); void'(rd_hist.pop_back());
        end
    end

    function automatic int exp_oe();
        return (cs_hist[1] == 0 && rd_hist[1] == 0) ? 1 : 0;
    endfunction

    function automatic int exp_data();
        if (exp_oe() == 0 || busy) return 0;
        return (m_ptr == 0) ? (m_res >> 2) : ((m_res & 3) << 6);
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!done) begin
            vectors++;
            if (int'(bus_oe) != exp_oe()) begin
                errors++;
                $display("FAIL R1 bus_oe actual %0d expected %0d at %0t", bus_oe, exp_oe(), $time);
            end
            vectors++;
            if (int'(bus_data) != exp_data()) begin
                errors++;
                if (busy) $display("FAIL R7 bus_data actual %h expected %h", bus_data, exp_data());
                else if (m_ptr == 0) $display("FAIL R2 bus_data actual %h expected %h", bus_data, exp_data());
                else $display("FAIL R3 bus_data actual %h expected %h", bus_data, exp_data());
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_read(output int value);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        tick(4);
        #2 value = int'(bus_data);
        @(negedge clk);
        rd_n = 1'b1;
        tick(4);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic convert(input int value, input bit valid);
        @(negedge clk);
        busy = 1'b1;
        tick(4);
        busy = 1'b0; res_valid = valid; res_data = 10'(value);
        tick(1);
        res_valid = 1'b0; res_data = '0;
        tick(2);
    endtask

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            errors++;
            done = 1;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int v;
        tick(3);
        // R9: reset state
        check("R9 oe", int'(bus_oe), 0);
        check("R9 data", int'(bus_data), 0);
        rst_n = 1'b1;
        tick(2);
        host_read(v);
        check("R9 first byte after reset", v, 0);
        host_read(v);

        // R10: strobe latency
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); #1 check("R10 one edge", int'(bus_oe), 0);
        @(negedge clk); #1 check("R10 two edges", int'(bus_oe), 1);
        @(negedge clk); rd_n = 1'b1; tick(4); cs_n = 1'b1; tick(3);
        // that access advanced the pointer; convert to rewind

        convert(10'h2D7, 1'b1);
        host_read(v); check("R2 msb", v, 8'hB5);
        host_read(v); check("R3 lsb", v, 8'hC0);
        host_read(v); check("R4 msb again", v, 8'hB5);
        host_read(v); check("R4 lsb again", v, 8'hC0);

        // R5: one read then new conversion rewinds
        convert(10'h3FF, 1'b1);
        host_read(v); check("R5 first", v, 8'hFF);
        convert(10'h001, 1'b1);
        host_read(v); check("R5 rewound", v, 8'h00);
        host_read(v); check("R3 lsb 01", v, 8'h40);

        // R6: busy fall without valid keeps result
        convert(10'h155, 1'b0);
        host_read(v); check("R6 held msb", v, 8'h00);
        host_read(v); check("R6 held lsb", v, 8'h40);

        // R7: reads during busy return zero and do not move pointer
        @(negedge clk); busy = 1'b1;
        tick(2);
        host_read(v); check("R7 busy read", v, 0);
        host_read(v); check("R7 busy read 2", v, 0);
        host_read(v);
        @(negedge clk); busy = 1'b0;
        tick(2);
        host_read(v); check("R7 pointer frozen", v, 8'h00);

        // R8: read pulse with chip-select high
        convert(10'h2AA, 1'b1);
        @(negedge clk); rd_n = 1'b0; tick(4); rd_n = 1'b1; tick(4);
        host_read(v); check("R8 still msb", v, 8'hAA);
        // R1: read low with cs high never enables
        @(negedge clk); rd_n = 1'b0; tick(4); #1 check("R1 cs high", int'(bus_oe), 0);
        @(negedge clk); rd_n = 1'b1; tick(4);
        host_read(v); check("R3 lsb 2AA", v, 8'h80);

        tick(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule